// File: doc/BRIEF.md
# History-Aware DRAM Command Arbiter

This block chooses which pending DRAM command leaves the read and write reorder queues next and enters the in-order memory queue. It keeps the last two commands it issued as its state. Each cycle it gives every valid candidate a small conflict score against that history and offers the cheapest one. The offer goes out on a valid/ready handshake. The ranking rules are fixed in hardware. They encode bank conflicts, read-after-write turnaround on a rank, and write-after-read port switches.

When two candidates score the same, a running mix credit breaks the tie. The credit rises by one for every read issued and falls by a configured weight for every write. It is compared with a configured target, which steers the stream toward the desired read:write ratio. If a tie remains after that, the lowest candidate index wins, because that slot holds the oldest command. The history and the credit change only when the memory queue accepts a command.

Top module: `hba_arbiter`

## Requirements
- R1: After reset both history slots are empty (`hist_valid` = 0, both history words 0), `mix_credit` is 0, and every candidate scores zero.
- R2: When no candidate is valid, `grant_valid` is 0 and the history and credit keep their values across the clock edge.
- R3: When any candidate is valid, `grant_valid` is 1, the granted candidate is valid, and no valid candidate has a lower conflict score.
- R4: Same-bank conflict: a candidate adds 3 if it has the same rank and bank as the most recent command, and 2 if it has the same rank and bank as the older command.
- R5: A read candidate adds 2 when the most recent command is a write to the same rank.
- R6: A write candidate adds 1 when the most recent command is a read on a different port.
- R7: The score of a candidate is the sum of every term in R4 to R6 that applies to it.
- R8: Among candidates with the lowest score, a read is preferred when `mix_credit` < `mix_target` (signed), and a write is preferred otherwise.
- R9: A tie that remains after R8 goes to the lowest candidate index.
- R10: When `grant_valid` and `grant_ready` are both high at a rising edge, the granted command becomes the recent history entry and the previous recent entry becomes the older entry. Without that handshake, both entries hold.
- R11: On a handshake, `mix_credit` rises by 1 for a read or falls by `wr_weight` for a write. It saturates at the limits of its signed width (−32 to 31 by default).
- R12: A history word packs the command as {write bit [5], rank [4:3], bank [2:1], port [0]}. `hist_valid[0]` flags the recent entry and `hist_valid[1]` flags the older entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid | input | N_CAND | Candidate present, one bit per slot |
| cand_wr | input | N_CAND | 1 = write, 0 = read, per slot |
| cand_rank | input | 2·N_CAND | Rank of each slot, slot i at [2i+1:2i] |
| cand_bank | input | 2·N_CAND | Bank of each slot, slot i at [2i+1:2i] |
| cand_port | input | N_CAND | Port of each slot |
| mix_target | input | CREDIT_W | Signed credit target for the mix tie-break |
| wr_weight | input | WEIGHT_W | Amount a write subtracts from the credit |
| grant_valid | output | 1 | A command is offered |
| grant_ready | input | 1 | Memory queue accepts the offer |
| grant_idx | output | $clog2(N_CAND) | Slot of the offered command |
| hist_valid | output | 2 | Occupancy of the recent [0] and older [1] history entries |
| hist_recent | output | 6 | Most recently issued command |
| hist_older | output | 6 | Command issued before that |
| mix_credit | output | CREDIT_W | Signed read/write mix credit |

## Verification
Directed patterns isolate each score term. A same-bank pair is tried against the recent entry and then against the older entry, which shows that the two weights differ. A read behind a write on the same rank, and a write behind a read across ports, each check one turnaround term. A case where the sum of two small terms beats a single large one tells additive scoring apart from taking the maximum term. Pairs with equal scores are tried with the target on either side of the credit, and then with same-class pairs, which separates the mix tie-break from index order. Stalled offers and empty cycles show that the state moves only on a handshake. A long pseudo-random stream with random ready is then compared every cycle against a behavioural model, and runs of reads and writes drive the credit into both saturation limits.

// File: rtl/hba_pkg.sv
`timescale 1ns/1ps
package hba_pkg;
  localparam int RANK_W = 2;
  localparam int BANK_W = 2;
  localparam int PORT_W = 1;
  localparam int CMD_W  = 1 + RANK_W + BANK_W + PORT_W;
  localparam int COST_W = 4;

  typedef struct packed {
    logic              wr;
    logic [RANK_W-1:0] rank;
    logic [BANK_W-1:0] bank;
    logic [PORT_W-1:0] port;
  } cmd_t;

  localparam logic [COST_W-1:0] W_BANK_RECENT = 4'd3;
  localparam logic [COST_W-1:0] W_BANK_OLDER  = 4'd2;
  localparam logic [COST_W-1:0] W_RD_AFTER_WR = 4'd2;
  localparam logic [COST_W-1:0] W_WR_AFTER_RD = 4'd1;

  function automatic logic same_bank(input cmd_t a, input cmd_t b);
    return (a.rank == b.rank) && (a.bank == b.bank);
  endfunction

  // Conflict score of one candidate against the two-entry history.
  function automatic logic [COST_W-1:0] conflict_cost(
    input cmd_t c, input logic rv, input cmd_t r, input logic ov, input cmd_t o);
    logic [COST_W-1:0] s;
    s = '0;
    if (rv && same_bank(c, r))                      s = s + W_BANK_RECENT;
    if (ov && same_bank(c, o))                      s = s + W_BANK_OLDER;
    if (rv && !c.wr && r.wr && (c.rank == r.rank))  s = s + W_RD_AFTER_WR;
    if (rv && c.wr && !r.wr && (c.port != r.port))  s = s + W_WR_AFTER_RD;
    return s;
  endfunction
endpackage

// File: rtl/hba_cost_unit.sv
`timescale 1ns/1ps
module hba_cost_unit
  import hba_pkg::*;
(
  input  cmd_t              cand,
  input  logic              recent_v,
  input  cmd_t              recent,
  input  logic              older_v,
  input  cmd_t              older,
  output logic [COST_W-1:0] cost
);
  assign cost = conflict_cost(cand, recent_v, recent, older_v, older);
endmodule

// File: rtl/hba_pick.sv
`timescale 1ns/1ps
module hba_pick
  import hba_pkg::*;
#(
  parameter int N_CAND = 8,
  localparam int IDX_W = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
  input  logic [N_CAND-1:0]        valid,
  input  logic [N_CAND-1:0]        is_wr,
  input  logic [N_CAND*COST_W-1:0] cost_vec,
  input  logic                     prefer_wr,
  output logic                     any,
  output logic [IDX_W-1:0]         idx
);
  logic [COST_W-1:0] best_cost;
  logic              best_mis;
  logic [COST_W-1:0] c_i;
  logic              m_i;

  // Ordered scan: lower score first, then class match, then lowest slot.
  always_comb begin
    any       = 1'b0;
    idx       = '0;
    best_cost = '1;
    best_mis  = 1'b1;
    c_i       = '0;
    m_i       = 1'b0;
    for (int i = 0; i < N_CAND; i++) begin
      c_i = cost_vec[i*COST_W +: COST_W];
      m_i = (is_wr[i] != prefer_wr);
      if (valid[i]) begin
        if (!any || (c_i < best_cost) || ((c_i == best_cost) && !m_i && best_mis)) begin
          any       = 1'b1;
          idx       = IDX_W'(i);
          best_cost = c_i;
          best_mis  = m_i;
        end
      end
    end
  end
endmodule

// File: rtl/hba_history.sv
`timescale 1ns/1ps
module hba_history
  import hba_pkg::*;
#(
  parameter int CREDIT_W = 6,
  parameter int WEIGHT_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  cmd_t                       push_cmd,
  input  logic [WEIGHT_W-1:0]        wr_weight,
  output logic                       recent_v,
  output cmd_t                       recent,
  output logic                       older_v,
  output cmd_t                       older,
  output logic signed [CREDIT_W-1:0] credit
);
  localparam int CMAX = (1 << (CREDIT_W-1)) - 1;
  localparam int CMIN = -(1 << (CREDIT_W-1));

  function automatic logic signed [CREDIT_W-1:0] step_credit(
    input logic signed [CREDIT_W-1:0] cur, input logic wr, input logic [WEIGHT_W-1:0] w);
    int v;
    v = int'(cur);
    if (wr) v = v - int'({1'b0, w});
    else    v = v + 1;
    if (v > CMAX) v = CMAX;
    if (v < CMIN) v = CMIN;
    return v[CREDIT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recent_v <= 1'b0;
      recent   <= '0;
      older_v  <= 1'b0;
      older    <= '0;
      credit   <= '0;
    end else if (push) begin
      older_v  <= recent_v;
      older    <= recent;
      recent_v <= 1'b1;
      recent   <= push_cmd;
      credit   <= step_credit(credit, push_cmd.wr, wr_weight);
    end
  end
endmodule

// File: rtl/hba_arbiter.sv
`timescale 1ns/1ps
module hba_arbiter
  import hba_pkg::*;
#(
  parameter int N_CAND   = 8,
  parameter int CREDIT_W = 6,
  parameter int WEIGHT_W = 3,
  localparam int IDX_W   = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_CAND-1:0]          cand_valid,
  input  logic [N_CAND-1:0]          cand_wr,
  input  logic [N_CAND*RANK_W-1:0]   cand_rank,
  input  logic [N_CAND*BANK_W-1:0]   cand_bank,
  input  logic [N_CAND*PORT_W-1:0]   cand_port,
  input  logic signed [CREDIT_W-1:0] mix_target,
  input  logic [WEIGHT_W-1:0]        wr_weight,
  output logic                       grant_valid,
  input  logic                       grant_ready,
  output logic [IDX_W-1:0]           grant_idx,
  output logic [1:0]                 hist_valid,
  output logic [CMD_W-1:0]           hist_recent,
  output logic [CMD_W-1:0]           hist_older,
  output logic signed [CREDIT_W-1:0] mix_credit
);
  cmd_t                    cand_cmd [N_CAND];
  logic [N_CAND*COST_W-1:0] cost_vec;
  logic                    recent_v, older_v;
  cmd_t                    recent, older;
  logic                    prefer_wr;
  logic                    handshake;
  cmd_t                    sel_cmd;

  for (genvar g = 0; g < N_CAND; g++) begin : g_cand
    assign cand_cmd[g] = '{wr:   cand_wr[g],
                           rank: cand_rank[g*RANK_W +: RANK_W],
                           bank: cand_bank[g*BANK_W +: BANK_W],
                           port: cand_port[g*PORT_W +: PORT_W]};
    hba_cost_unit u_cost (
      .cand     (cand_cmd[g]),
      .recent_v (recent_v),
      .recent   (recent),
      .older_v  (older_v),
      .older    (older),
      .cost     (cost_vec[g*COST_W +: COST_W])
    );
  end

  assign prefer_wr = !(mix_credit < mix_target);

  hba_pick #(.N_CAND(N_CAND)) u_pick (
    .valid     (cand_valid),
    .is_wr     (cand_wr),
    .cost_vec  (cost_vec),
    .prefer_wr (prefer_wr),
    .any       (grant_valid),
    .idx       (grant_idx)
  );

  assign sel_cmd   = cand_cmd[grant_idx];
  assign handshake = grant_valid && grant_ready;

  hba_history #(.CREDIT_W(CREDIT_W), .WEIGHT_W(WEIGHT_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (handshake),
    .push_cmd  (sel_cmd),
    .wr_weight (wr_weight),
    .recent_v  (recent_v),
    .recent    (recent),
    .older_v   (older_v),
    .older     (older),
    .credit    (mix_credit)
  );

  assign hist_valid  = {older_v, recent_v};
  assign hist_recent = recent;
  assign hist_older  = older;
endmodule

// File: rtl/hba_arbiter_chk.sv
`timescale 1ns/1ps
module hba_arbiter_chk
  import hba_pkg::*;
#(
  parameter int N_CAND   = 8,
  parameter int CREDIT_W = 6,
  localparam int IDX_W   = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_CAND-1:0]          cand_valid,
  input logic                       grant_valid,
  input logic                       grant_ready,
  input logic [IDX_W-1:0]           grant_idx,
  input logic [N_CAND*COST_W-1:0]   cost_vec,
  input logic [CMD_W-1:0]           sel_cmd,
  input logic [1:0]                 hist_valid,
  input logic [CMD_W-1:0]           hist_recent,
  input logic [CMD_W-1:0]           hist_older,
  input logic signed [CREDIT_W-1:0] mix_credit
);
  localparam logic signed [CREDIT_W-1:0] CMAX = {1'b0, {(CREDIT_W-1){1'b1}}};

  assert_reset_empty_R1: assert property (@(posedge clk) $rose(rst_n) |-> (hist_valid == 2'b00));

  assert_idle_no_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid == '0) |-> !grant_valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid == '0) |=> ($stable(hist_recent) && $stable(mix_credit)));

  assert_grant_valid_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> cand_valid[grant_idx]);

  assert_some_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid != '0) |-> grant_valid);

  for (genvar i = 0; i < N_CAND; i++) begin : g_min
    assert_min_cost_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && cand_valid[i]) |->
        (cost_vec[grant_idx*COST_W +: COST_W] <= cost_vec[i*COST_W +: COST_W]));
  end

  assert_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_ready) |=>
      ((hist_recent == $past(sel_cmd)) && (hist_older == $past(hist_recent)) && hist_valid[0]));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_valid && grant_ready) |=>
      ($stable(hist_recent) && $stable(hist_older) && $stable(hist_valid)));

  assert_read_credit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_ready && !sel_cmd[CMD_W-1] && (mix_credit != CMAX)) |=>
      (mix_credit == $past(mix_credit) + CREDIT_W'(1)));
endmodule

bind hba_arbiter hba_arbiter_chk #(.N_CAND(N_CAND), .CREDIT_W(CREDIT_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cand_valid  (cand_valid),
  .grant_valid (grant_valid),
  .grant_ready (grant_ready),
  .grant_idx   (grant_idx),
  .cost_vec    (cost_vec),
  .sel_cmd     (sel_cmd),
  .hist_valid  (hist_valid),
  .hist_recent (hist_recent),
  .hist_older  (hist_older),
  .mix_credit  (mix_credit)
);

// File: tb/test_hba_arbiter.sv
`timescale 1ns/1ps
module test_hba_arbiter;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        cv = '0, cw = '0, cpt = '0;
  logic [15:0]       crk = '0, cbk = '0;
  logic signed [5:0] tgt = '0;
  logic [2:0]        wgt = 3'd1;
  logic              rdy = 1'b0;
  logic              gv;
  logic [2:0]        gidx;
  logic [1:0]        hv;
  logic [5:0]        hrec, hold;
  logic signed [5:0] cred;

  int n_chk = 0, n_fail = 0;
  // behavioural model state
  int m_v0 = 0, m_v1 = 0, m_h0 = 0, m_h1 = 0, m_cr = 0;

  always #10 clk = ~clk;

  hba_arbiter i_hba_arbiter (
    .clk(clk), .rst_n(rst_n), .cand_valid(cv), .cand_wr(cw), .cand_rank(crk),
    .cand_bank(cbk), .cand_port(cpt), .mix_target(tgt), .wr_weight(wgt),
    .grant_valid(gv), .grant_ready(rdy), .grant_idx(gidx), .hist_valid(hv),
    .hist_recent(hrec), .hist_older(hold), .mix_credit(cred));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int enc(input int w, input int r, input int b, input int p);
    return w*32 + r*8 + b*2 + p;
  endfunction

  // score from the written rules, history held as packed integers
  function automatic int mcost(input int i);
    int w, r, b, p, s;
    w = cw[i]; r = crk[2*i +: 2]; b = cbk[2*i +: 2]; p = cpt[i];
    s = 0;
    if (m_v0 != 0 && r == (m_h0/8)%4 && b == (m_h0/2)%4) s += 3;
    if (m_v1 != 0 && r == (m_h1/8)%4 && b == (m_h1/2)%4) s += 2;
    if (m_v0 != 0 && w == 0 && m_h0/32 == 1 && r == (m_h0/8)%4) s += 2;
    if (m_v0 != 0 && w == 1 && m_h0/32 == 0 && p != m_h0%2) s += 1;
    return s;
  endfunction

  task automatic mpick(output int v, output int idx);
    int pw, bc, bm, c, m;
    v = 0; idx = 0; bc = 0; bm = 0;
    pw = (m_cr < int'(tgt)) ? 0 : 1;
    for (int i = 0; i < 8; i++) begin
      if (cv[i]) begin
        c = mcost(i);
        m = (int'(cw[i]) != pw) ? 1 : 0;
        if (v == 0 || c < bc || (c == bc && m < bm)) begin
          v = 1; idx = i; bc = c; bm = m;
        end
      end
    end
  endtask

  // Compare every output with the model, optionally check a directed index,
  // then let the edge happen and advance the model.
  task automatic step(input int exp_idx, input string req);
    int ev, ei;
    #2;
    mpick(ev, ei);
    chk("R3 grant_valid", int'(gv), ev);
    if (ev != 0) chk("R3 grant_idx", int'(gidx), ei);
    chk("R10 hist_valid", int'(hv), m_v1*2 + m_v0);
    chk("R10 hist_recent", int'(hrec), m_h0);
    chk("R10 hist_older", int'(hold), m_h1);
    chk("R11 mix_credit", int'(cred), m_cr);
    if (exp_idx == -2) chk(req, int'(gv), 0);
    else if (exp_idx >= 0) begin
      chk(req, int'(gv), 1);
      chk(req, int'(gidx), exp_idx);
    end
    @(posedge clk);
    if (ev != 0 && rdy) begin
      m_v1 = m_v0; m_h1 = m_h0; m_v0 = 1;
      m_h0 = enc(cw[ei], crk[2*ei +: 2], cbk[2*ei +: 2], cpt[ei]);
      if (cw[ei]) m_cr = m_cr - int'(wgt); else m_cr = m_cr + 1;
      if (m_cr > 31) m_cr = 31;
      if (m_cr < -32) m_cr = -32;
    end
    @(negedge clk);
  endtask

  task automatic setc(input int i, input int w, input int r, input int b, input int p);
    cv[i] = 1'b1; cw[i] = w[0]; crk[2*i +: 2] = r[1:0]; cbk[2*i +: 2] = b[1:0]; cpt[i] = p[0];
  endtask

  task automatic issue(input int w, input int r, input int b, input int p);
    cv = '0; setc(0, w, r, b, p); rdy = 1'b1;
    step(0, "R10 issue");
    rdy = 1'b0; cv = '0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty history and zero credit after reset
    chk("R1 hist_valid", int'(hv), 0);
    chk("R1 hist_recent", int'(hrec), 0);
    chk("R1 mix_credit", int'(cred), 0);
    // R1: all-same candidates score zero, slot 0 wins
    for (int i = 0; i < 8; i++) setc(i, 0, 1, 1, 0);
    tgt = 6'sd0;
    step(0, "R1 zero cost");
    // R8: credit 0 not below target 0 -> prefer write
    cv = '0; setc(0, 0, 0, 0, 0); setc(3, 1, 1, 1, 0);
    step(3, "R8 prefer write");
    tgt = 6'sd1;
    step(0, "R8 prefer read");
    // R9: two equal reads
    cv = '0; setc(2, 0, 0, 0, 0); setc(5, 0, 3, 3, 1);
    step(2, "R9 lowest index");
    // R12: issue read rank1 bank2 port0 -> word 12
    issue(0, 1, 2, 0);
    chk("R12 encoding", int'(hrec), 12);
    chk("R12 valid bits", int'(hv), 1);
    // R4 recent-bank conflict
    tgt = 6'sd20;
    cv = '0; setc(0, 0, 1, 2, 0); setc(1, 0, 2, 0, 0);
    step(1, "R4 recent bank");
    issue(0, 3, 3, 1);  // recent r3b3, older r1b2
    cv = '0; setc(0, 0, 1, 2, 0); setc(1, 0, 0, 0, 0);
    step(1, "R4 older bank");
    cv = '0; setc(0, 0, 1, 2, 0); setc(1, 0, 3, 3, 0);
    step(0, "R4 older 2 below recent 3");
    // R5 read after write same rank
    issue(1, 0, 0, 0);
    cv = '0; setc(0, 0, 0, 1, 0); setc(1, 1, 2, 1, 0);
    step(1, "R5 read after write");
    // R6 write after read, other port
    issue(0, 0, 0, 0);
    tgt = -6'sd30;
    cv = '0; setc(0, 1, 2, 0, 1); setc(1, 1, 3, 1, 0);
    step(1, "R6 write after read");
    cv = '0; setc(0, 1, 2, 0, 1); setc(1, 0, 3, 1, 0);
    step(1, "R6 cost before mix");
    // R7 additive: older bank 2 + turnaround 2 = 4 loses to recent bank 3
    issue(0, 1, 1, 0);
    issue(1, 1, 3, 0);
    tgt = 6'sd20;
    cv = '0; setc(0, 0, 1, 1, 0); setc(1, 1, 1, 3, 0);
    step(1, "R7 sum of terms");
    // R2 no candidate
    snap = int'(hrec);
    cv = '0; rdy = 1'b1;
    step(-2, "R2 no grant");
    step(-2, "R2 no grant");
    chk("R2 history kept", int'(hrec), snap);
    // R10 stalled offer
    rdy = 1'b0; setc(0, 0, 2, 2, 1);
    step(0, "R10 stalled");
    chk("R10 stall keeps history", int'(hrec), snap);
    // R11 credit steps and saturation
    wgt = 3'd2;
    snap = int'(cred);
    issue(0, 2, 2, 0);
    chk("R11 read +1", int'(cred), snap + 1);
    issue(1, 2, 1, 0);
    chk("R11 write -weight", int'(cred), snap - 1);
    for (int k = 0; k < 40; k++) issue(0, k % 4, (k / 4) % 4, k % 2);
    chk("R11 upper saturation", int'(cred), 31);
    wgt = 3'd3;
    for (int k = 0; k < 30; k++) issue(1, k % 4, k % 3, 0);
    chk("R11 lower saturation", int'(cred), -32);
    // pseudo-random stream against the model
    for (int k = 0; k < 4000; k++) begin
      cv = 8'($urandom); cw = 8'($urandom); cpt = 8'($urandom);
      crk = 16'($urandom); cbk = 16'($urandom);
      rdy = ($urandom % 4) != 0;
      if (k % 50 == 0) begin
        tgt = 6'($urandom % 16) - 6'sd8;
        wgt = 3'($urandom);
      end
      step(-1, "R3 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule